// File: doc/BRIEF.md
# Symbol-Correcting Latin-Square Decoder with Concurrent Self-Check

This block decodes a word of a nonbinary orthogonal Latin square code whose symbols are `SYM_W` bits wide. Its parity-check matrix holds only zeros and ones, so every check and syndrome symbol is a bitwise XOR of whole symbols. Each bit plane therefore behaves as an independent binary code. A word carries `SQ*SQ` data symbols and `2*T_CORR*SQ` check symbols. Up to `T_CORR` erroneous symbols are corrected in one pass, using one-step majority voting. With the defaults (3-bit symbols, square side 3, two-symbol correction), this is the 21-symbol code holding 9 data symbols.

The decoder is watched by a concurrent checker. For every check line group it folds the parity of all bits, both over the received check symbols and over the syndrome symbols. From these folds it builds two signal pairs: one guards the syndrome logic, the other guards the voters and the correcting XORs. A single two-rail checker merges the two pairs into one alarm pair. An internal fault that corrupts the output therefore shows up as an alarm in the same cycle that the corrupted word leaves the block.

The datapath is combinational and ends in one register stage. A word presented with `in_valid` high appears at the outputs on the next clock edge.

Top module: `ols_sym_decoder`

## Requirements
- R1: Data symbol (r,c) sits at bits [(r*SQ+c)*SYM_W +: SYM_W] of `rx_data`. Check symbol j of line group g sits at bits [(g*SQ+j)*SYM_W +: SYM_W] of `rx_check`. That check symbol is the XOR of every data symbol whose line index in group g equals j. The line index is r for g=0, c for g=1, and ((g-1)*r+c) mod SQ for g>=2. When the word is a valid codeword, such as data (1,2,3,0,0,0,0,0,0) with checks (0,0,0,1,2,3,1,2,3,1,2,3), the data is passed through unchanged and no alarm is raised.
- R2: A single corrupted symbol, at any of the 21 positions and with any nonzero magnitude, is corrected exactly, and no alarm is raised.
- R3: Any two corrupted symbols, at any positions and with any nonzero magnitudes, are corrected exactly, and no alarm is raised.
- R4: The correction applied to each data symbol is a bitwise majority over its 2*T_CORR syndrome symbols plus one zero symbol. Take all data zero, with the four syndrome symbols of data symbol 0 set to (3,3,4,5). Data symbol 0 then comes out as 1, every other data symbol comes out as 0, and the alarm is raised.
- R5: The alarm pair reads healthy when `alarm_p` differs from `alarm_n`. It reads fault when the two are equal.
- R6: With the error-pattern net held at a stuck value, each output word is either correct or accompanied by an alarm. A stuck value that changes the output always raises the alarm.
- R7: With a syndrome net held at a stuck value, each output word is either correct or accompanied by an alarm.
- R8: `out_valid` follows `in_valid` with one cycle of latency. While `in_valid` is low, `out_data`, `alarm_p` and `alarm_n` hold their values.
- R9: During reset, `out_valid` is 0, `out_data` is 0 and the alarm pair is healthy (`alarm_p`=1, `alarm_n`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Received word present; clock enable of the output stage |
| rx_data | input | SQ*SQ*SYM_W (27) | Received data symbols |
| rx_check | input | 2*T_CORR*SQ*SYM_W (36) | Received check symbols |
| out_valid | output | 1 | Decoded word present |
| out_data | output | SQ*SQ*SYM_W (27) | Corrected data symbols |
| alarm_p | output | 1 | Alarm rail, 1 when healthy at reset |
| alarm_n | output | 1 | Alarm rail, complement of `alarm_p` when healthy |

## Verification
The clean-word assertion assumes that a word with an all-zero syndrome carries no error. It therefore requires the decoded data to equal the received data, unless an alarm is raised. The rail assertion assumes that both checker pairs agree whenever the decoder is fault-free and no more than `T_CORR` symbols are corrupted. To respect these assumptions, the stimulus builds every word from a bench encoder and corrupts at most two symbols. The single exception is the deliberate majority corner case, whose nonzero syndrome keeps it outside the clean-word assertion. Stuck-at faults are forced only on the error-pattern and syndrome nets. Against those faults, the alarm or the correct output is expected.

// File: rtl/ols_pkg.sv
package ols_pkg;
  // Line index of data symbol (r,c) inside line group g of a square of side sq.
  function automatic int line_of(input int g, input int r, input int c, input int sq);
    if (g == 0) return r;
    if (g == 1) return c;
    return ((g - 1) * r + c) % sq;
  endfunction
endpackage

// File: rtl/ols_syndrome.sv
module ols_syndrome
  import ols_pkg::*;
#(
  parameter int SYM_W  = 3,
  parameter int SQ     = 3,
  parameter int T_CORR = 2
) (
  input  logic [SQ*SQ*SYM_W-1:0]        rx_data,
  input  logic [2*T_CORR*SQ*SYM_W-1:0]  rx_check,
  output logic [2*T_CORR*SQ*SYM_W-1:0]  synd,
  output logic [2*T_CORR-1:0]           cpar,
  output logic [2*T_CORR-1:0]           spar
);
  localparam int GRP = 2 * T_CORR;
  localparam int GW  = SQ * SYM_W;

  // Recompute each check symbol from the data and compare with the received one.
  always_comb begin
    synd = rx_check;
    for (int g = 0; g < GRP; g++) begin
      for (int r = 0; r < SQ; r++) begin
        for (int c = 0; c < SQ; c++) begin
          synd[(g*SQ + line_of(g, r, c, SQ))*SYM_W +: SYM_W] ^=
            rx_data[(r*SQ + c)*SYM_W +: SYM_W];
        end
      end
    end
  end

  // Group parities folded across all bit planes.
  for (genvar g = 0; g < GRP; g++) begin : g_fold
    assign cpar[g] = ^rx_check[g*GW +: GW];
    assign spar[g] = ^synd[g*GW +: GW];
  end
endmodule

// File: rtl/ols_voter_array.sv
module ols_voter_array
  import ols_pkg::*;
#(
  parameter int SYM_W  = 3,
  parameter int SQ     = 3,
  parameter int T_CORR = 2
) (
  input  logic [2*T_CORR*SQ*SYM_W-1:0] synd,
  output logic [SQ*SQ*SYM_W-1:0]       err_pat
);
  localparam int K   = SQ * SQ;
  localparam int GRP = 2 * T_CORR;
  localparam int CW  = $clog2(GRP + 2);

  // One voter per data bit; the implicit zero input makes the threshold T_CORR+1.
  for (genvar p = 0; p < K; p++) begin : g_sym
    for (genvar bb = 0; bb < SYM_W; bb++) begin : g_bit
      logic [CW-1:0] ones;
      always_comb begin
        ones = '0;
        for (int g = 0; g < GRP; g++) begin
          ones += CW'(synd[(g*SQ + line_of(g, p / SQ, p % SQ, SQ))*SYM_W + bb]);
        end
      end
      assign err_pat[p*SYM_W + bb] = (ones > CW'(T_CORR));
    end
  end
endmodule

// File: rtl/ols_ced.sv
module ols_ced #(
  parameter int SYM_W  = 3,
  parameter int SQ     = 3,
  parameter int T_CORR = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [2*T_CORR-1:0]     cpar,
  input  logic [2*T_CORR-1:0]     spar,
  input  logic [SQ*SQ*SYM_W-1:0]  fixed,
  output logic                    z_p,
  output logic                    z_n
);
  localparam int GRP = 2 * T_CORR;
  localparam int CW  = $clog2(GRP + 2);

  logic [CW-1:0] c_ones, s_ones;
  logic syn_a, syn_b, oth_a, oth_b;

  always_comb begin
    c_ones = '0;
    s_ones = '0;
    for (int g = 0; g < GRP; g++) begin
      c_ones += CW'(cpar[g]);
      s_ones += CW'(spar[g]);
    end
  end

  assign syn_a = ^cpar;
  assign syn_b = ^spar;
  // Tie in the syndrome count selects the first-group fold, else a majority with zero.
  assign oth_a = (s_ones == CW'(T_CORR)) ? (cpar[0] ^ spar[0]) : (c_ones > CW'(T_CORR));
  assign oth_b = ^fixed;

  // Two-rail merge: the second member of each pair is taken inverted.
  assign z_p = (syn_a & oth_a) | (~syn_b & ~oth_b);
  assign z_n = (syn_a & ~oth_b) | (~syn_b & oth_a);

  AST_RAIL_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    (syn_a == syn_b) && (oth_a == oth_b) |-> (z_p != z_n)); // R5
endmodule

// File: rtl/ols_sym_decoder.sv
module ols_sym_decoder #(
  parameter int SYM_W  = 3,
  parameter int SQ     = 3,
  parameter int T_CORR = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              in_valid,
  input  logic [SQ*SQ*SYM_W-1:0]            rx_data,
  input  logic [2*T_CORR*SQ*SYM_W-1:0]      rx_check,
  output logic                              out_valid,
  output logic [SQ*SQ*SYM_W-1:0]            out_data,
  output logic                              alarm_p,
  output logic                              alarm_n
);
  localparam int DW  = SQ * SQ * SYM_W;
  localparam int CHW = 2 * T_CORR * SQ * SYM_W;
  localparam int GRP = 2 * T_CORR;

  logic [CHW-1:0] synd;
  logic [GRP-1:0] cpar, spar;
  logic [DW-1:0]  err_pat, fixed;
  logic           z_p, z_n;

  ols_syndrome #(.SYM_W(SYM_W), .SQ(SQ), .T_CORR(T_CORR)) i_syn (
    .rx_data(rx_data), .rx_check(rx_check), .synd(synd), .cpar(cpar), .spar(spar));

  ols_voter_array #(.SYM_W(SYM_W), .SQ(SQ), .T_CORR(T_CORR)) i_vote (
    .synd(synd), .err_pat(err_pat));

  assign fixed = rx_data ^ err_pat;

  ols_ced #(.SYM_W(SYM_W), .SQ(SQ), .T_CORR(T_CORR)) i_ced (
    .clk(clk), .rst_n(rst_n), .cpar(cpar), .spar(spar), .fixed(fixed),
    .z_p(z_p), .z_n(z_n));

  // Output stage: next-state then register.
  logic [DW-1:0] data_d;
  logic          ap_d, an_d;

  always_comb begin
    data_d = out_data;
    ap_d   = alarm_p;
    an_d   = alarm_n;
    if (in_valid) begin
      data_d = fixed;
      ap_d   = z_p;
      an_d   = z_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      alarm_p   <= 1'b1;
      alarm_n   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_data  <= data_d;
      alarm_p   <= ap_d;
      alarm_n   <= an_d;
    end
  end

  // Checking support.
  logic armed;
  logic clean;
  assign clean = ~|synd;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (out_valid == $past(in_valid))); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !$past(in_valid) |-> $stable(out_data) && $stable(alarm_p) && $stable(alarm_n)); // R8
  AST_CLEAN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(in_valid && clean) |-> (out_data == $past(rx_data)) || (alarm_p == alarm_n)); // R1
endmodule

// File: tb/test_ols_sym_decoder.sv
`timescale 1ns/1ps
module test_ols_sym_decoder;
  localparam int B   = 3;
  localparam int M   = 3;
  localparam int T   = 2;
  localparam int K   = M * M;
  localparam int G   = 2 * T;
  localparam int DW  = K * B;
  localparam int CHW = G * M * B;
  localparam int N   = K + G * M;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic [DW-1:0]  rx_data;
  logic [CHW-1:0] rx_check;
  logic out_valid;
  logic [DW-1:0] out_data;
  logic alarm_p, alarm_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  ols_sym_decoder #(.SYM_W(B), .SQ(M), .T_CORR(T)) i_ols_sym_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .rx_data(rx_data),
    .rx_check(rx_check), .out_valid(out_valid), .out_data(out_data),
    .alarm_p(alarm_p), .alarm_n(alarm_n));

  function automatic int line_idx(input int g, input int r, input int c);
    if (g == 0) return r;
    if (g == 1) return c;
    return ((g - 1) * r + c) % M;
  endfunction

  function automatic logic [CHW-1:0] encode(input logic [DW-1:0] d);
    logic [CHW-1:0] ch = '0;
    for (int g = 0; g < G; g++)
      for (int r = 0; r < M; r++)
        for (int c = 0; c < M; c++)
          ch[(g*M + line_idx(g, r, c))*B +: B] ^= d[(r*M + c)*B +: B];
    return ch;
  endfunction

  function automatic logic [DW-1:0] rand_data();
    logic [DW-1:0] d;
    for (int i = 0; i < K; i++) d[i*B +: B] = B'($urandom_range(0, 7));
    return d;
  endfunction

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp, input logic ap, input logic an);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: out=%h alarm=%b%b expected out=%h", req, act, ap, an, exp);
    end
  endtask

  // Flip symbol pos of the 21-symbol word by mag.
  task automatic corrupt(inout logic [DW-1:0] d, inout logic [CHW-1:0] ch,
                         input int pos, input logic [B-1:0] mag);
    if (pos < K) d[pos*B +: B] ^= mag;
    else         ch[(pos-K)*B +: B] ^= mag;
  endtask

  task automatic apply(input logic [DW-1:0] d, input logic [CHW-1:0] ch);
    @(negedge clk);
    rx_data  = d;
    rx_check = ch;
    in_valid = 1'b1;
    @(posedge clk);
    #1;
  endtask

  task automatic expect_clean(input string req, input logic [DW-1:0] exp);
    check(out_valid && out_data == exp && alarm_p != alarm_n, req, out_data, exp, alarm_p, alarm_n);
  endtask

  task automatic expect_safe(input string req, input logic [DW-1:0] exp);
    check(out_data == exp || alarm_p == alarm_n, req, out_data, exp, alarm_p, alarm_n);
  endtask

  task automatic expect_alarm(input string req, input logic [DW-1:0] exp);
    check(alarm_p == alarm_n, req, out_data, exp, alarm_p, alarm_n);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: out=%h expected completion", out_data);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0]  d, dd;
    logic [CHW-1:0] ch, cc;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    rx_data  = '0;
    rx_check = '0;
    repeat (3) @(posedge clk);
    #1;
    // R9 reset state
    check(!out_valid && out_data == '0 && alarm_p == 1'b1 && alarm_n == 1'b0,
          "R9", out_data, '0, alarm_p, alarm_n);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 stated codeword
    d = '0;
    d[0 +: B] = 3'd1; d[B +: B] = 3'd2; d[2*B +: B] = 3'd3;
    ch = '0;
    for (int j = 3; j < 12; j++) ch[j*B +: B] = B'(((j - 3) % 3) + 1);
    apply(d, ch);
    expect_clean("R1", d);
    check(encode(d) == ch, "R1", out_data, d, alarm_p, alarm_n);

    // R1 random clean codewords
    for (int i = 0; i < 60; i++) begin
      d = rand_data();
      apply(d, encode(d));
      expect_clean("R1", d);
    end

    // R2 every position, every nonzero magnitude
    for (int p = 0; p < N; p++) begin
      for (int mg = 1; mg < 8; mg++) begin
        d = rand_data(); ch = encode(d); dd = d; cc = ch;
        corrupt(dd, cc, p, B'(mg));
        apply(dd, cc);
        expect_clean("R2", d);
      end
    end

    // R3 every pair of positions, random magnitudes
    for (int rep = 0; rep < 2; rep++) begin
      for (int p = 0; p < N; p++) begin
        for (int q = p + 1; q < N; q++) begin
          d = rand_data(); ch = encode(d); dd = d; cc = ch;
          corrupt(dd, cc, p, B'($urandom_range(1, 7)));
          corrupt(dd, cc, q, B'($urandom_range(1, 7)));
          apply(dd, cc);
          expect_clean("R3", d);
        end
      end
    end

    // R4 majority corner case: syndromes (3,3,4,5) on data symbol 0
    d = '0; ch = '0;
    ch[0*B +: B] = 3'd3; ch[3*B +: B] = 3'd3; ch[6*B +: B] = 3'd4; ch[9*B +: B] = 3'd5;
    dd = '0; dd[0 +: B] = 3'd1;
    apply(d, ch);
    check(out_data == dd, "R4", out_data, dd, alarm_p, alarm_n);
    expect_alarm("R4", dd);
    // R5 alarm pair reads fault as equal rails
    check(alarm_p == alarm_n, "R5", out_data, dd, alarm_p, alarm_n);

    // R8 hold while idle
    d = rand_data();
    apply(d, encode(d));
    expect_clean("R8", d);
    @(negedge clk);
    in_valid = 1'b0;
    rx_data  = rand_data();
    rx_check = '1;
    @(posedge clk); #1;
    check(!out_valid && out_data == d && alarm_p != alarm_n, "R8", out_data, d, alarm_p, alarm_n);
    @(posedge clk); #1;
    check(!out_valid && out_data == d && alarm_p != alarm_n, "R8", out_data, d, alarm_p, alarm_n);

    // R6 stuck-at-1 on error pattern bit 4, clean words: output altered, alarm required
    force i_ols_sym_decoder.err_pat[4] = 1'b1;
    for (int i = 0; i < 20; i++) begin
      d = rand_data();
      apply(d, encode(d));
      expect_alarm("R6", d);
    end
    release i_ols_sym_decoder.err_pat[4];
    // R6 stuck-at-0 on bit 4 while symbol 1 carries magnitude 2
    force i_ols_sym_decoder.err_pat[4] = 1'b0;
    for (int i = 0; i < 20; i++) begin
      d = rand_data(); ch = encode(d); dd = d;
      dd[B +: B] ^= 3'd2;
      apply(dd, ch);
      expect_alarm("R6", d);
    end
    release i_ols_sym_decoder.err_pat[4];
    // R6 stuck-at-1 on bit 20, mixed single errors
    force i_ols_sym_decoder.err_pat[20] = 1'b1;
    for (int i = 0; i < 30; i++) begin
      d = rand_data(); ch = encode(d); dd = d; cc = ch;
      corrupt(dd, cc, $urandom_range(0, N - 1), B'($urandom_range(1, 7)));
      apply(dd, cc);
      expect_safe("R6", d);
    end
    release i_ols_sym_decoder.err_pat[20];

    // R7 stuck-at on syndrome bits
    force i_ols_sym_decoder.synd[7] = 1'b1;
    for (int i = 0; i < 30; i++) begin
      d = rand_data(); ch = encode(d); dd = d; cc = ch;
      if (i % 2 == 1) corrupt(dd, cc, $urandom_range(0, N - 1), B'($urandom_range(1, 7)));
      apply(dd, cc);
      expect_safe("R7", d);
    end
    release i_ols_sym_decoder.synd[7];
    force i_ols_sym_decoder.synd[30] = 1'b0;
    for (int i = 0; i < 30; i++) begin
      d = rand_data(); ch = encode(d); dd = d; cc = ch;
      corrupt(dd, cc, $urandom_range(0, N - 1), B'($urandom_range(1, 7)));
      apply(dd, cc);
      expect_safe("R7", d);
    end
    release i_ols_sym_decoder.synd[30];

    // recovery after faults are released
    d = rand_data();
    apply(d, encode(d));
    expect_clean("R1", d);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule